// File: doc/BRIEF.md
# Pulse Width and Period Accumulator

This block times a digital input against a free-running 24-bit timebase that the chip supplies. In period mode it measures the time between one rising edge and the next. In high-time mode it measures from a rising edge to the falling edge that follows it. Each measurement is added to a running sum. When a programmed number of measurements, from 1 to 255, has been summed, the total is moved into a held result register, an interrupt is raised and a new window starts.

Software sets the mode and the window length through a small register port, and reads the finished total there. Dividing the total by the window length gives an average. A window length of 1 gives one value per input cycle. The held result does not change while the next window builds. The running sum saturates rather than wrapping, and a sticky flag records that it did.

Register map, by two-bit address:
- 0, control: bit 0 selects the mode (0 = period, 1 = high time), and bits 15:8 hold the window length.
- 1, result: the held total, zero-extended to 32 bits.
- 2, status: bit 0 is the pending interrupt and bit 1 is the saturation flag. Writing 1 to a bit clears it.
- 3: reads as zero.

Top module: `pulse_period_accum`

## Requirements
- R1: The input passes through two synchronizing flops. An input change is acted on at the third rising clock edge after it, using the timebase value present just before that edge.
- R2: In period mode (control bit 0 = 0), each measurement is the timebase difference between consecutive rising edges, and falling edges have no effect. The rising edge that closes one measurement also opens the next.
- R3: In high-time mode (control bit 0 = 1), each measurement is the difference from a rising edge to the next falling edge. Time spent low is not counted.
- R4: Differences are taken modulo 2^24, so one wrap of the timebase within a measurement still gives the true elapsed count.
- R5: A window holds the number of measurements set in control bits 15:8. The result (address 1) is the sum of that window's measurements. With a length of 1, each measurement is reported on its own.
- R6: The interrupt output rises only when a window completes. It stays high until 1 is written to status bit 0.
- R7: The result keeps its value while the next window accumulates, until that window completes.
- R8: If the sum would exceed 2^SUM_W-1, it stays at all ones and status bit 1 is set. Status bit 1 stays set until 1 is written to it.
- R9: Any write to the control register discards the sum in progress and the measurement count, and waits for a new rising edge. A length of 0 is stored as 1.
- R10: After reset, control reads 0x100, result reads 0, status reads 0 and the interrupt is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sigIn | input | 1 | Measured input, asynchronous |
| timebase | input | TB_W | Free-running timebase value |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational on regAddr |
| irq | output | 1 | Window-complete interrupt, level |

## Verification
On every cycle, the assertions check several invariants. The measurement count stays below the window length. A control write empties the sum. The held result changes only on a window-completing strobe. A saturated sum stays at all ones. The interrupt and the saturation flag rise and clear only for their proper causes. Only the bench scenarios can show the measured values themselves: rise-to-rise versus rise-to-fall timing, ignored falling edges, timebase wrap, multi-window totals, saturation of a real stream, and a restart in mid-window. The bench shows these by comparing each interrupt's result against totals it predicts independently.

// File: rtl/pwa_pkg.sv
package pwa_pkg;

  typedef enum logic [1:0] {
    ST_WAIT_RISE = 2'd0,
    ST_RUN       = 2'd1,
    ST_HIGH      = 2'd2
  } pwaState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadStamp;
    logic addMeas;
    logic finish;
    logic clearSum;
  } pwaStrobe_t;

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_RESULT = 2'd1;
  localparam logic [1:0] ADDR_STATUS = 2'd2;

endpackage

// File: rtl/pwa_ctrl.sv
module pwa_ctrl
  import pwa_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sigIn,
  input  logic             modeWidth,
  input  logic [CNT_W-1:0] periodCount,
  input  logic             restart,
  output pwaStrobe_t       strobe
);

  logic [1:0]       syncQ;
  logic             prevQ;
  logic             riseDet;
  logic             fallDet;
  pwaState_e        stateQ, stateNext;
  logic [CNT_W-1:0] windowCnt, windowCntNext;
  logic             lastMeas;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[0], sigIn};
      prevQ <= syncQ[1];
    end
  end

  assign riseDet  = syncQ[1] & ~prevQ;
  assign fallDet  = ~syncQ[1] & prevQ;
  assign lastMeas = (windowCnt == periodCount - CNT_W'(1));

  always_comb begin
    strobe        = '0;
    stateNext     = stateQ;
    windowCntNext = windowCnt;
    if (restart) begin
      strobe.clearSum = 1'b1;
      stateNext       = ST_WAIT_RISE;
      windowCntNext   = '0;
    end else begin
      unique case (stateQ)
        ST_WAIT_RISE: begin
          if (riseDet) begin
            strobe.loadStamp = 1'b1;
            stateNext        = modeWidth ? ST_HIGH : ST_RUN;
          end
        end
        ST_RUN: begin
          if (riseDet) begin
            strobe.loadStamp = 1'b1;
            strobe.addMeas   = 1'b1;
            if (lastMeas) begin
              strobe.finish = 1'b1;
              windowCntNext = '0;
            end else begin
              windowCntNext = windowCnt + CNT_W'(1);
            end
          end
        end
        ST_HIGH: begin
          if (fallDet) begin
            strobe.addMeas = 1'b1;
            stateNext      = ST_WAIT_RISE;
            if (lastMeas) begin
              strobe.finish = 1'b1;
              windowCntNext = '0;
            end else begin
              windowCntNext = windowCnt + CNT_W'(1);
            end
          end
        end
        default: stateNext = ST_WAIT_RISE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= ST_WAIT_RISE;
      windowCnt <= '0;
    end else begin
      stateQ    <= stateNext;
      windowCnt <= windowCntNext;
    end
  end

  // R5: count never reaches the programmed window length
  a_r5_cnt_below_limit: assert property (@(posedge clk) disable iff (!rstN)
    windowCnt < periodCount);

  // R1: a detected rise was on the first sync stage one cycle earlier
  a_r1_rise_from_sync: assert property (@(posedge clk) disable iff (!rstN)
    riseDet |-> $past(syncQ[0]));

  // R3: in high-time mode a measurement closes only from the high state
  a_r3_width_from_high: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.addMeas && modeWidth) |-> (stateQ == ST_HIGH));

endmodule

// File: rtl/pwa_datapath.sv
module pwa_datapath
  import pwa_pkg::*;
#(
  parameter int TB_W  = 24,
  parameter int SUM_W = 28
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [TB_W-1:0]  timebase,
  input  pwaStrobe_t       strobe,
  output logic [SUM_W-1:0] resultQ,
  output logic             ovfEvt
);

  localparam int EXT_W = SUM_W + 1 - TB_W;

  logic [TB_W-1:0]  stampQ;
  logic [TB_W-1:0]  measDiff;
  logic [SUM_W-1:0] sumQ;
  logic [SUM_W:0]   sumWide;
  logic [SUM_W-1:0] sumSat;

  // modulo 2^TB_W difference covers one wrap of the timebase
  assign measDiff = timebase - stampQ;
  assign sumWide  = {1'b0, sumQ} + {{EXT_W{1'b0}}, measDiff};
  assign sumSat   = sumWide[SUM_W] ? {SUM_W{1'b1}} : sumWide[SUM_W-1:0];
  assign ovfEvt   = strobe.addMeas & sumWide[SUM_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stampQ  <= '0;
      sumQ    <= '0;
      resultQ <= '0;
    end else begin
      if (strobe.loadStamp) stampQ <= timebase;
      if (strobe.clearSum) begin
        sumQ <= '0;
      end else if (strobe.finish) begin
        resultQ <= sumSat;
        sumQ    <= '0;
      end else if (strobe.addMeas) begin
        sumQ <= sumSat;
      end
    end
  end

  a_r7_result_holds: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.finish |=> $stable(resultQ));

  a_r8_sat_sticks: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.addMeas && !strobe.finish && !strobe.clearSum && (sumQ == {SUM_W{1'b1}}))
      |=> (sumQ == {SUM_W{1'b1}}));

  a_r5_sum_grows: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.addMeas && !strobe.finish && !strobe.clearSum) |=> (sumQ >= $past(sumQ)));

  a_r9_restart_clears: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearSum |=> (sumQ == '0));

endmodule

// File: rtl/pwa_regs.sv
module pwa_regs
  import pwa_pkg::*;
#(
  parameter int SUM_W = 28,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [1:0]       regAddr,
  input  logic [31:0]      regWdata,
  output logic [31:0]      regRdata,
  input  logic             doneEvt,
  input  logic             ovfEvt,
  input  logic [SUM_W-1:0] resultQ,
  output logic             modeWidth,
  output logic [CNT_W-1:0] periodCount,
  output logic             restart,
  output logic             irq
);

  logic             ovfQ;
  logic             statusWr;
  logic [CNT_W-1:0] cntField;

  assign restart  = regWe && (regAddr == ADDR_CTRL);
  assign statusWr = regWe && (regAddr == ADDR_STATUS);
  assign cntField = regWdata[8 +: CNT_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeWidth   <= 1'b0;
      periodCount <= CNT_W'(1);
      irq         <= 1'b0;
      ovfQ        <= 1'b0;
    end else begin
      if (restart) begin
        modeWidth   <= regWdata[0];
        periodCount <= (cntField == '0) ? CNT_W'(1) : cntField;
      end
      if (doneEvt)                    irq <= 1'b1;
      else if (statusWr && regWdata[0]) irq <= 1'b0;
      if (ovfEvt)                     ovfQ <= 1'b1;
      else if (statusWr && regWdata[1]) ovfQ <= 1'b0;
    end
  end

  always_comb begin
    regRdata = '0;
    unique case (regAddr)
      ADDR_CTRL: begin
        regRdata[0]          = modeWidth;
        regRdata[8 +: CNT_W] = periodCount;
      end
      ADDR_RESULT: regRdata[SUM_W-1:0] = resultQ;
      ADDR_STATUS: regRdata[1:0]       = {ovfQ, irq};
      default:     regRdata = '0;
    endcase
  end

  a_r6_irq_needs_done: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(doneEvt));

  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (ovfQ && !(statusWr && regWdata[1])) |=> ovfQ);

  a_r9_count_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    periodCount != '0);

endmodule

// File: rtl/pulse_period_accum.sv
module pulse_period_accum
  import pwa_pkg::*;
#(
  parameter int TB_W  = 24,
  parameter int SUM_W = 28,
  parameter int CNT_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            sigIn,
  input  logic [TB_W-1:0] timebase,
  input  logic            regWe,
  input  logic [1:0]      regAddr,
  input  logic [31:0]     regWdata,
  output logic [31:0]     regRdata,
  output logic            irq
);

  pwaStrobe_t       strobe;
  logic [SUM_W-1:0] resultQ;
  logic             ovfEvt;
  logic             modeWidth;
  logic [CNT_W-1:0] periodCount;
  logic             restart;

  pwa_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sigIn(sigIn), .modeWidth(modeWidth),
    .periodCount(periodCount), .restart(restart), .strobe(strobe)
  );

  pwa_datapath #(.TB_W(TB_W), .SUM_W(SUM_W)) u_dp (
    .clk(clk), .rstN(rstN), .timebase(timebase), .strobe(strobe),
    .resultQ(resultQ), .ovfEvt(ovfEvt)
  );

  pwa_regs #(.SUM_W(SUM_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .doneEvt(strobe.finish),
    .ovfEvt(ovfEvt), .resultQ(resultQ), .modeWidth(modeWidth),
    .periodCount(periodCount), .restart(restart), .irq(irq)
  );

endmodule

// File: tb/sim_pulse_period_accum.sv
module sim_pulse_period_accum;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sigIn = 1'b0;
  logic [23:0] timebase = '0;
  logic        regWe = 1'b0;
  logic [1:0]  regAddr = 2'd1;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        irq;

  int total = 0;
  int fails = 0;
  logic [31:0] expQ[$];

  always #10 clk = ~clk;

  pulse_period_accum #(.TB_W(24), .SUM_W(28), .CNT_W(8)) u0 (
    .clk(clk), .rstN(rstN), .sigIn(sigIn), .timebase(timebase),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // hold timebase over the three-edge synchronizer latency (R1)
  task automatic edgeAt(input logic lvl, input logic [23:0] t);
    @(negedge clk);
    timebase = t;
    sigIn    = lvl;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulseAt(input logic [23:0] t);
    edgeAt(1'b1, t);
    edgeAt(1'b0, t + 24'd3);
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); #3;
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk); #3;
    regWe = 1'b0; regAddr = 2'd1; regWdata = '0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk); #3;
    regAddr = a;
    #1 v = regRdata;
    regAddr = 2'd1;
  endtask

  task automatic waitQuiet();
    repeat (3) @(negedge clk);
    while (expQ.size() != 0 || irq) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // monitor: every interrupt pops one expected total
  initial begin
    logic [31:0] e;
    forever begin
      @(negedge clk); #2;
      if (irq) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R6 unexpected irq", {31'b0, irq}, 32'd0);
        end else begin
          e = expQ.pop_front();
          check(regRdata == e, "R5 window total", regRdata, e);
        end
        regWe = 1'b1; regAddr = 2'd2; regWdata = 32'd1;
        @(posedge clk); #1;
        regWe = 1'b0; regAddr = 2'd1; regWdata = '0;
        @(negedge clk); #2;
        check(!irq, "R6 irq cleared by status write", {31'b0, irq}, 32'd0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", 32'd0, 32'd1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R10 reset state
    readReg(2'd0, v); check(v == 32'h100, "R10 ctrl reset", v, 32'h100);
    readReg(2'd1, v); check(v == 32'h0, "R10 result reset", v, 32'h0);
    readReg(2'd2, v); check(v == 32'h0, "R10 status reset", v, 32'h0);
    check(!irq, "R10 irq reset", {31'b0, irq}, 32'd0);

    // R9 length 0 stored as 1
    writeReg(2'd0, 32'h0);
    readReg(2'd0, v); check(v == 32'h100, "R9 zero length", v, 32'h100);

    // R2 R5 R1: period mode, length 1, falls ignored
    writeReg(2'd0, 32'h100);
    edgeAt(1'b1, 24'd100); edgeAt(1'b0, 24'd150);
    expQ.push_back(32'd300);
    edgeAt(1'b1, 24'd400); edgeAt(1'b0, 24'd500);
    expQ.push_back(32'd600);
    edgeAt(1'b1, 24'd1000); edgeAt(1'b0, 24'd1001);
    waitQuiet();

    // R5 R7: length 3, result held while next window builds
    writeReg(2'd0, 32'h300);
    pulseAt(24'd0); pulseAt(24'd10); pulseAt(24'd30);
    expQ.push_back(32'd60);
    pulseAt(24'd60);
    pulseAt(24'd160); pulseAt(24'd360);
    readReg(2'd1, v); check(v == 32'd60, "R7 held result", v, 32'd60);
    check(!irq, "R6 no irq mid-window", {31'b0, irq}, 32'd0);
    expQ.push_back(32'd600);
    pulseAt(24'd660);
    waitQuiet();

    // R4 timebase wrap
    writeReg(2'd0, 32'h100);
    pulseAt(24'hFFFF00);
    expQ.push_back(32'h200);
    pulseAt(24'h000100);
    waitQuiet();

    // R3 high-time mode, length 2
    writeReg(2'd0, 32'h201);
    edgeAt(1'b1, 24'd1000); edgeAt(1'b0, 24'd1040);
    edgeAt(1'b1, 24'd5000);
    expQ.push_back(32'd140);
    edgeAt(1'b0, 24'd5100);
    waitQuiet();

    // R9 restart mid-window discards partial sum
    writeReg(2'd0, 32'h200);
    pulseAt(24'd0); pulseAt(24'd100);
    writeReg(2'd0, 32'h200);
    pulseAt(24'd5000); pulseAt(24'd5050);
    expQ.push_back(32'd80);
    pulseAt(24'd5080);
    waitQuiet();

    // R8 saturation: 19 periods of 0xF00000 exceed 2^28-1
    writeReg(2'd0, 32'h1300);
    pulseAt(24'd0);
    for (int k = 1; k <= 19; k++) begin
      if (k == 19) expQ.push_back(32'h0FFF_FFFF);
      pulseAt(24'(k * 32'hF00000));
    end
    waitQuiet();
    readReg(2'd2, v); check(v == 32'h2, "R8 sticky overflow", v, 32'h2);
    writeReg(2'd2, 32'h2);
    readReg(2'd2, v); check(v == 32'h0, "R8 overflow cleared", v, 32'h0);

    check(expQ.size() == 0, "R6 all windows reported", expQ.size(), 32'd0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule